// File: doc/BRIEF.md
# Real-Time-Clock Bus Transaction Monitor

This block watches traffic going to a BCD real-time-clock device on a two-wire serial bus. It does not decode bits on the wire. Its input is a stream of bus events that an upstream decoder has already produced. Each event carries a kind code and one byte.

The monitor follows the transaction in steps:

- It tracks the device address and the register pointer.
- It catches the pattern "set pointer, repeated start, read back".
- It routes each data byte, written or read, into the clock field that the pointer selects.

The seconds, minutes, hours, weekday, day-of-month, month and year are held in binary. The monitor also keeps the 12-hour and PM flags. When a STOP closes a write transaction, a one-cycle completion pulse fires for that direction. A STOP that closes a read transaction fires the read pulse instead. The held fields stay valid while either pulse is high.

The event input is a valid/ready stream. The monitor never applies back-pressure, so `evt_ready` is always high. An event is consumed on every rising clock edge where `evt_valid` is high. A producer may therefore treat valid alone as the transfer condition. The completion pulses and the field outputs are plain status pins and have no handshake.

Top module: `rtcmon_top`

## Requirements
- R1: After reset both completion pulses are 0, every clock field is 0 (year therefore reads 2000), both hour flags are 0, and `evt_ready` is 1 at all times.
- R2: Event kind codes are: 0 = START, 1 = repeated START, 2 = address-write, 3 = address-read, 4 = data-write, 5 = data-read, 6 = STOP. The sequence START, address-write with byte 0x68, then data-write loads that byte as the register pointer. Each later data-write updates the field at the pointer and then advances the pointer by one. Field order by pointer is: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day-of-month, 5 month, 6 year, 7 control (no field).
- R3: In the write phase, a repeated START followed by address-read with byte 0x68 enters the read phase. Data-read bytes then update fields from the current pointer onward, and the pointer advances by one per byte.
- R4: A data byte at a pointer of 8 or above (a RAM access) changes no field but still advances the pointer.
- R5: Each field is the low nibble plus ten times the high nibble of the byte, after these masks:
  - seconds and minutes: 0x7F
  - weekday: 0x07
  - day-of-month: 0x3F
  - month: 0x1F
  - year: no mask
- R6: For the hours byte, bit 6 = 1 selects 12-hour mode: the hour comes from bits 4:0 and the PM flag is bit 5. Bit 6 = 0 selects 24-hour mode: the hour comes from bits 5:0 and the PM flag is 0.
- R7: The year output is the decoded two-digit value plus 2000.
- R8: A STOP in the write phase raises `done_wr` for exactly one cycle, one clock after the STOP is consumed. A STOP in the read phase does the same on `done_rd`. In both cases the monitor then returns to idle.
- R9: An address event whose byte is not 0x68, received while an address is expected, returns the monitor to idle. Data that follows it changes no field and no STOP pulse follows.
- R10: An event that does not fit the current step is ignored. The exception is START, which restarts the sequence from any step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event present on this cycle |
| evt_ready | output | 1 | Always 1, no back-pressure |
| evt_kind | input | 3 | Event kind code (see R2) |
| evt_byte | input | 8 | Byte carried by the event |
| done_wr | output | 1 | One-cycle write-transaction-complete pulse |
| done_rd | output | 1 | One-cycle read-transaction-complete pulse |
| t_sec | output | 8 | Seconds, binary |
| t_min | output | 8 | Minutes, binary |
| t_hour | output | 8 | Hours, binary |
| t_hour12 | output | 1 | Last hours byte selected 12-hour mode |
| t_pm | output | 1 | PM flag in 12-hour mode |
| t_wday | output | 8 | Weekday, binary |
| t_mday | output | 8 | Day of month, binary |
| t_month | output | 8 | Month, binary |
| t_year | output | 12 | Full year (2000 plus two digits) |

## Verification
The assertions check several properties on every cycle:
- The two completion pulses never overlap, and each pulse lasts exactly one cycle.
- A pulse appears only right after a consumed STOP.
- The fields move only in the cycle after a consumed data event.
- The PM flag is never set outside 12-hour mode, and the year stays in its possible range.

Some behaviour can only be shown by the bench scenarios:
- Pointer routing across a burst, and the pointer carrying over from the write phase into the read phase.
- RAM bytes being skipped.
- The reserved-bit masks.
- Foreign-address aborts, and restarts in the middle of a transaction.

The bench shows these by comparing against a behavioural model and against known field values.

// File: rtl/rtcmon_pkg.sv
package rtcmon_pkg;

  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_RSTART  = 3'd1,
    EV_ADDR_WR = 3'd2,
    EV_ADDR_RD = 3'd3,
    EV_DATA_WR = 3'd4,
    EV_DATA_RD = 3'd5,
    EV_STOP    = 3'd6,
    EV_NONE    = 3'd7
  } ev_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DEV    = 3'd1,
    ST_REGPTR = 3'd2,
    ST_WRITE  = 3'd3,
    ST_RDADDR = 3'd4,
    ST_READ   = 3'd5
  } mon_state_e;

  localparam int BYTE_W    = 8;
  localparam int PTR_W     = 8;
  localparam int NUM_TIME  = 7;   // seconds .. year
  localparam int IDX_SEC   = 0;
  localparam int IDX_MIN   = 1;
  localparam int IDX_HOUR  = 2;
  localparam int IDX_WDAY  = 3;
  localparam int IDX_MDAY  = 4;
  localparam int IDX_MONTH = 5;
  localparam int IDX_YEAR  = 6;

  // Two-digit BCD to binary: low digit plus ten times high digit.
  function automatic logic [BYTE_W-1:0] bcd_to_bin(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
    hi = {4'd0, b[7:4]};
    lo = {4'd0, b[3:0]};
    return (hi << 3) + (hi << 1) + lo;
  endfunction

  // Reserved-bit mask of each time register; hours depends on its mode bit.
  function automatic logic [BYTE_W-1:0] field_mask(input int idx,
                                                  input logic [BYTE_W-1:0] b);
    case (idx)
      IDX_SEC, IDX_MIN: return 8'h7F;
      IDX_HOUR:         return b[6] ? 8'h1F : 8'h3F;
      IDX_WDAY:         return 8'h07;
      IDX_MDAY:         return 8'h3F;
      IDX_MONTH:        return 8'h1F;
      default:          return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/rtcmon_seq.sv
module rtcmon_seq
  import rtcmon_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_fire,
  input  logic [2:0]        ev_kind,
  input  logic [BYTE_W-1:0] ev_byte,
  output logic              dec_en,
  output logic [PTR_W-1:0]  dec_ptr,
  output logic              done_wr,
  output logic              done_rd
);

  mon_state_e       state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             pulse_wr_d, pulse_rd_d;
  ev_kind_e         kind;
  logic             addr_hit;

  assign kind     = ev_kind_e'(ev_kind);
  assign addr_hit = (ev_byte == {1'b0, DEV_ADDR});

  always_comb begin
    state_d    = state_q;
    ptr_d      = ptr_q;
    pulse_wr_d = 1'b0;
    pulse_rd_d = 1'b0;
    dec_en     = 1'b0;
    if (ev_fire) begin
      if (kind == EV_START) begin
        state_d = ST_DEV;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_DEV: begin
            if (kind == EV_ADDR_WR || kind == EV_ADDR_RD) begin
              if (!addr_hit)                 state_d = ST_IDLE;
              else if (kind == EV_ADDR_WR)   state_d = ST_REGPTR;
            end
          end
          ST_REGPTR: begin
            if (kind == EV_DATA_WR) begin
              ptr_d   = ev_byte[PTR_W-1:0];
              state_d = ST_WRITE;
            end
          end
          ST_WRITE: begin
            if (kind == EV_DATA_WR) begin
              dec_en = 1'b1;
              ptr_d  = ptr_q + 1'b1;
            end else if (kind == EV_RSTART) begin
              state_d = ST_RDADDR;
            end else if (kind == EV_STOP) begin
              pulse_wr_d = 1'b1;
              state_d    = ST_IDLE;
            end
          end
          ST_RDADDR: begin
            if (kind == EV_ADDR_WR || kind == EV_ADDR_RD) begin
              if (!addr_hit)                 state_d = ST_IDLE;
              else if (kind == EV_ADDR_RD)   state_d = ST_READ;
            end
          end
          ST_READ: begin
            if (kind == EV_DATA_RD) begin
              dec_en = 1'b1;
              ptr_d  = ptr_q + 1'b1;
            end else if (kind == EV_STOP) begin
              pulse_rd_d = 1'b1;
              state_d    = ST_IDLE;
            end
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  assign dec_ptr = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      done_wr <= 1'b0;
      done_rd <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      done_wr <= pulse_wr_d;
      done_rd <= pulse_rd_d;
    end
  end

endmodule

// File: rtl/rtcmon_fields.sv
module rtcmon_fields
  import rtcmon_pkg::*;
#(
  parameter int RAM_BASE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_en,
  input  logic [PTR_W-1:0]  dec_ptr,
  input  logic [BYTE_W-1:0] dec_byte,
  output logic [BYTE_W-1:0] fld [NUM_TIME],
  output logic              hour12,
  output logic              pm
);

  logic in_time_space;
  assign in_time_space = (int'(dec_ptr) < RAM_BASE);

  for (genvar i = 0; i < NUM_TIME; i++) begin : g_field
    logic hit;
    assign hit = dec_en && in_time_space && (int'(dec_ptr) == i);
    always_ff @(posedge clk) begin
      if (!rst_n)   fld[i] <= '0;
      else if (hit) fld[i] <= bcd_to_bin(dec_byte & field_mask(i, dec_byte));
    end
  end

  logic hour_hit;
  assign hour_hit = dec_en && in_time_space && (int'(dec_ptr) == IDX_HOUR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hour12 <= 1'b0;
      pm     <= 1'b0;
    end else if (hour_hit) begin
      hour12 <= dec_byte[6];
      pm     <= dec_byte[6] & dec_byte[5];
    end
  end

endmodule

// File: rtl/rtcmon_top.sv
module rtcmon_top
  import rtcmon_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h68,
  parameter int         RAM_BASE  = 8,
  parameter int         YEAR_BASE = 2000,
  parameter int         YEAR_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [2:0]        evt_kind,
  input  logic [7:0]        evt_byte,
  output logic              done_wr,
  output logic              done_rd,
  output logic [7:0]        t_sec,
  output logic [7:0]        t_min,
  output logic [7:0]        t_hour,
  output logic              t_hour12,
  output logic              t_pm,
  output logic [7:0]        t_wday,
  output logic [7:0]        t_mday,
  output logic [7:0]        t_month,
  output logic [YEAR_W-1:0] t_year
);

  logic              dec_en;
  logic [PTR_W-1:0]  dec_ptr;
  logic [BYTE_W-1:0] fld [NUM_TIME];
  logic              ev_fire;

  assign evt_ready = 1'b1;
  assign ev_fire   = evt_valid & evt_ready;

  rtcmon_seq #(.DEV_ADDR(DEV_ADDR)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_fire (ev_fire),
    .ev_kind (evt_kind),
    .ev_byte (evt_byte),
    .dec_en  (dec_en),
    .dec_ptr (dec_ptr),
    .done_wr (done_wr),
    .done_rd (done_rd)
  );

  rtcmon_fields #(.RAM_BASE(RAM_BASE)) u_fields (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec_en   (dec_en),
    .dec_ptr  (dec_ptr),
    .dec_byte (evt_byte),
    .fld      (fld),
    .hour12   (t_hour12),
    .pm       (t_pm)
  );

  assign t_sec   = fld[IDX_SEC];
  assign t_min   = fld[IDX_MIN];
  assign t_hour  = fld[IDX_HOUR];
  assign t_wday  = fld[IDX_WDAY];
  assign t_mday  = fld[IDX_MDAY];
  assign t_month = fld[IDX_MONTH];
  assign t_year  = YEAR_W'(YEAR_BASE) + YEAR_W'(fld[IDX_YEAR]);

endmodule

// File: rtl/rtcmon_chk.sv
module rtcmon_chk #(
  parameter int YEAR_BASE = 2000,
  parameter int YEAR_W    = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic [2:0]        evt_kind,
  input logic              done_wr,
  input logic              done_rd,
  input logic [7:0]        t_sec,
  input logic [7:0]        t_min,
  input logic [7:0]        t_hour,
  input logic              t_hour12,
  input logic              t_pm,
  input logic [7:0]        t_wday,
  input logic [7:0]        t_mday,
  input logic [7:0]        t_month,
  input logic [YEAR_W-1:0] t_year
);

  logic data_evt;
  logic stop_evt;
  assign data_evt = evt_valid && (evt_kind == 3'd4 || evt_kind == 3'd5);
  assign stop_evt = evt_valid && (evt_kind == 3'd6);

  a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_wr && done_rd));

  a_r8_wr_follows_stop: assert property (@(posedge clk) disable iff (!rst_n)
    done_wr |-> $past(stop_evt));

  a_r8_rd_follows_stop: assert property (@(posedge clk) disable iff (!rst_n)
    done_rd |-> $past(stop_evt));

  a_r8_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_wr |=> !done_wr);

  a_r8_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_rd |=> !done_rd);

  a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(data_evt) |-> $stable({t_sec, t_min, t_hour, t_hour12, t_pm,
                                  t_wday, t_mday, t_month, t_year}));

  a_r6_pm_needs_12h: assert property (@(posedge clk) disable iff (!rst_n)
    t_pm |-> t_hour12);

  a_r7_year_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(t_year) >= YEAR_BASE) && (int'(t_year) <= YEAR_BASE + 165));

endmodule

bind rtcmon_top rtcmon_chk #(.YEAR_BASE(YEAR_BASE), .YEAR_W(YEAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
  .done_wr(done_wr), .done_rd(done_rd), .t_sec(t_sec), .t_min(t_min),
  .t_hour(t_hour), .t_hour12(t_hour12), .t_pm(t_pm), .t_wday(t_wday),
  .t_mday(t_mday), .t_month(t_month), .t_year(t_year)
);

// File: tb/test_rtcmon_top.sv
`timescale 1ns/1ps
module test_rtcmon_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [2:0]  evt_kind = 3'd7;
  logic [7:0]  evt_byte = 8'd0;
  logic        done_wr, done_rd;
  logic [7:0]  t_sec, t_min, t_hour, t_wday, t_mday, t_month;
  logic        t_hour12, t_pm;
  logic [11:0] t_year;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  rtcmon_top i_rtcmon_top (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_kind(evt_kind), .evt_byte(evt_byte), .done_wr(done_wr),
    .done_rd(done_rd), .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour),
    .t_hour12(t_hour12), .t_pm(t_pm), .t_wday(t_wday), .t_mday(t_mday),
    .t_month(t_month), .t_year(t_year)
  );

  localparam int K_START = 0, K_RSTART = 1, K_AW = 2, K_AR = 3,
                 K_DW = 4, K_DR = 5, K_STOP = 6;

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_state;   // 0 idle,1 dev,2 regptr,3 write,4 rdaddr,5 read
  int m_ptr;
  int m_f [7];
  int m_h12, m_pm, m_dwr, m_drd;

  function automatic int bcd(input int b);
    return (b % 16) + 10 * (b / 16);
  endfunction

  function automatic void m_store(input int p, input int b);
    int v;
    if (p >= 8) return;
    case (p)
      0, 1: v = b & 'h7F;
      2:    v = (b & 'h40) ? (b & 'h1F) : (b & 'h3F);
      3:    v = b & 'h07;
      4:    v = b & 'h3F;
      5:    v = b & 'h1F;
      default: v = b;
    endcase
    m_f[p] = bcd(v);
    if (p == 2) begin
      m_h12 = (b >> 6) & 1;
      m_pm  = m_h12 & ((b >> 5) & 1);
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_ptr = 0; m_h12 = 0; m_pm = 0; m_dwr = 0; m_drd = 0;
      foreach (m_f[i]) m_f[i] = 0;
    end else begin
      m_dwr = 0; m_drd = 0;
      if (evt_valid) begin
        int k, b;
        k = int'(evt_kind); b = int'(evt_byte);
        if (k == K_START) m_state = 1;
        else if (m_state == 1 || m_state == 4) begin
          if (k == K_AW || k == K_AR) begin
            if (b != 'h68) m_state = 0;
            else if (m_state == 1 && k == K_AW) m_state = 2;
            else if (m_state == 4 && k == K_AR) m_state = 5;
          end
        end else if (m_state == 2) begin
          if (k == K_DW) begin m_ptr = b; m_state = 3; end
        end else if (m_state == 3) begin
          if (k == K_DW) begin m_store(m_ptr, b); m_ptr = (m_ptr + 1) % 256; end
          else if (k == K_RSTART) m_state = 4;
          else if (k == K_STOP) begin m_dwr = 1; m_state = 0; end
        end else if (m_state == 5) begin
          if (k == K_DR) begin m_store(m_ptr, b); m_ptr = (m_ptr + 1) % 256; end
          else if (k == K_STOP) begin m_drd = 1; m_state = 0; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R8", "done_wr vs model", int'(done_wr), m_dwr);
      check("R8", "done_rd vs model", int'(done_rd), m_drd);
      check("R2", "seconds vs model", int'(t_sec), m_f[0]);
      check("R2", "minutes vs model", int'(t_min), m_f[1]);
      check("R6", "hours vs model", int'(t_hour), m_f[2]);
      check("R6", "12h flag vs model", int'(t_hour12), m_h12);
      check("R6", "pm flag vs model", int'(t_pm), m_pm);
      check("R5", "weekday vs model", int'(t_wday), m_f[3]);
      check("R5", "mday vs model", int'(t_mday), m_f[4]);
      check("R5", "month vs model", int'(t_month), m_f[5]);
      check("R7", "year vs model", int'(t_year), 2000 + m_f[6]);
      check("R1", "ready", int'(evt_ready), 1);
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input int k, input int b);
    @(posedge clk); #1;
    evt_valid = 1'b1; evt_kind = 3'(k); evt_byte = 8'(b);
    @(posedge clk); #1;
    evt_valid = 1'b0; evt_kind = 3'd7;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=completion");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check("R1", "reset done_wr", int'(done_wr), 0);
    check("R1", "reset seconds", int'(t_sec), 0);
    check("R1", "reset year", int'(t_year), 2000);
    check("R1", "reset ready", int'(evt_ready), 1);
    rst_n = 1'b1;

    // Full write burst from pointer 0; seconds byte has bit 7 set.
    send(K_START, 0); send(K_AW, 'h68); send(K_DW, 'h00);
    send(K_DW, 'hC5); send(K_DW, 'h30); send(K_DW, 'h72);
    send(K_DW, 'h03); send(K_DW, 'h31); send(K_DW, 'h12); send(K_DW, 'h24);
    send(K_STOP, 0);
    check("R8", "write pulse after STOP", int'(done_wr), 1);
    check("R5", "seconds masked", int'(t_sec), 45);
    check("R2", "minutes", int'(t_min), 30);
    check("R6", "12h hour", int'(t_hour), 12);
    check("R6", "pm flag", int'(t_pm), 1);
    check("R5", "date", int'(t_mday), 31);
    check("R7", "year 2024", int'(t_year), 2024);
    @(posedge clk); #1;
    check("R8", "write pulse one cycle", int'(done_wr), 0);

    // Control then RAM bytes: no field moves.
    send(K_START, 0); send(K_AW, 'h68); send(K_DW, 'h07);
    send(K_DW, 'h93); send(K_DW, 'h11); send(K_DW, 'h22); send(K_STOP, 0);
    check("R4", "RAM leaves seconds", int'(t_sec), 45);
    check("R4", "RAM leaves year", int'(t_year), 2024);

    // Pointer set then read back through repeated START.
    send(K_START, 0); send(K_AW, 'h68); send(K_DW, 'h02);
    send(K_RSTART, 0); send(K_AR, 'h68);
    send(K_DR, 'h23); send(K_DR, 'h05); send(K_DR, 'hC9);
    send(K_STOP, 0);
    check("R3", "read pulse after STOP", int'(done_rd), 1);
    check("R6", "24h hour", int'(t_hour), 23);
    check("R6", "12h flag cleared", int'(t_hour12), 0);
    check("R3", "weekday read", int'(t_wday), 5);
    check("R5", "date masked", int'(t_mday), 9);

    // Foreign address: data must not land, no pulse.
    send(K_START, 0); send(K_AW, 'h50); send(K_DW, 'h00); send(K_DW, 'h11);
    send(K_STOP, 0);
    check("R9", "no pulse after foreign", int'(done_wr), 0);
    check("R9", "seconds untouched", int'(t_sec), 45);

    // Out-of-place events ignored; START restarts mid-transaction.
    send(K_START, 0); send(K_DR, 'h77); send(K_STOP, 0);
    send(K_AW, 'h68); send(K_DW, 'h01);
    send(K_START, 0); send(K_AW, 'h68); send(K_DW, 'h04);
    send(K_DW, 'h15); send(K_DR, 'h44); send(K_STOP, 0);
    check("R10", "restart write pulse", int'(done_wr), 1);
    check("R10", "minutes untouched", int'(t_min), 30);
    check("R10", "date after restart", int'(t_mday), 15);

    // Month mask and year top end.
    send(K_START, 0); send(K_AW, 'h68); send(K_DW, 'h05);
    send(K_DW, 'hF2); send(K_DW, 'h99); send(K_STOP, 0);
    check("R5", "month masked", int'(t_month), 12);
    check("R7", "year 2099", int'(t_year), 2099);

    repeat (3) @(posedge clk);
    #1;
    summary();
  end

endmodule